// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block carries out the stack side of taking an interrupt or exception and of returning from it. A request gives a vector number, a gate kind (interrupt or trap), the privilege level of the handler, and the handler's code selector and entry offset. The block saves the interrupted context as a frame of 32-bit words through a word-wide memory port. When the handler runs at a more privileged level, it first switches to that level's stack, taken from a small table held inside the block. It then loads the handler entry point and signals completion.

The matching return request reads the frame back from the current stack top. It restores the instruction pointer, code selector and flags. It also restores the interrupted stack when the saved code selector shows a less privileged level. Vectors that are reserved are refused with a protection fault indication, and memory is not touched. The block holds the architectural flags, code selector, instruction pointer, stack selector and stack pointer. The surrounding core loads them through a context strobe, and the stack table is written through the same buses.

Top module: `irq_frame_seq`

## Requirements
- R1: After a synchronous reset, busy, done, fault, mem_wr and mem_rd are low, flags reads 0x00000002, and cs, ip, ss and sp read zero.
- R2: The current privilege level is cs[1:0]. When ev_dpl is not below it, the frame goes on the current stack: the word at sp-4 is flags, the word at sp-8 is cs zero-extended, and the word at sp-12 is ip.
- R3: When ev_dpl is below the current level, ss and sp are first taken from table entry ev_dpl. Below that new top come, in descending addresses, the old ss zero-extended, the old sp, flags, cs zero-extended and ip.
- R4: Vectors 8, 10, 11, 12, 13, 14 and 17 push ev_err as one more word directly below ip. For every other vector no extra word is written and ev_err has no effect; the number of mem_wr cycles equals the frame length.
- R5: Each pushed word lowers sp by 4 and is written at the new sp, so after entry sp equals the starting top minus 4 times the word count.
- R6: After the frame, cs takes ev_sel and ip takes ev_off. done is high for exactly one cycle, first seen after the (N+2)th rising edge counting the edge that accepts the request, where N is the number of words pushed.
- R7: An interrupt gate (ev_trap low) clears flags bit 9 after the frame is written; the frame holds the old value. A trap gate (ev_trap high) leaves flags unchanged.
- R8: A request with vector 15 or 19 to 31 raises fault for one cycle, with fault_vec equal to 13. No word is written, and flags, cs, ip, ss and sp stay unchanged.
- R9: On ret_valid, five words are read upward from sp (ip, cs, flags, sp, ss). Memory must return the addressed word on mem_rdata in the cycle after mem_rd is high. ip, cs and flags are restored. If the popped cs[1:0] is not above the current level, sp advances by 12 and ss is kept.
- R10: If the popped cs[1:0] is above the current level, sp and ss are loaded from the fourth and fifth words, returning to the interrupted stack.
- R11: A completed return pulses done for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_valid | input | 1 | Event request strobe, taken when idle |
| ev_vec | input | 8 | Vector number |
| ev_trap | input | 1 | 1 = trap gate, 0 = interrupt gate |
| ev_dpl | input | 2 | Handler privilege level |
| ev_sel | input | 16 | Handler code selector |
| ev_off | input | 32 | Handler entry offset |
| ev_err | input | 32 | Error code word |
| ret_valid | input | 1 | Interrupt-return request strobe |
| ld_ctx | input | 1 | Load all context registers from the ld_* buses when idle |
| ld_flags | input | 32 | Flags value to load |
| ld_cs | input | 16 | Code selector to load |
| ld_ip | input | 32 | Instruction pointer to load |
| ld_ss | input | 16 | Stack selector for context load or table write |
| ld_sp | input | 32 | Stack pointer for context load or table write |
| tab_wr | input | 1 | Write ld_ss/ld_sp into stack table entry tab_lvl |
| tab_lvl | input | 2 | Stack table entry to write |
| mem_wr | output | 1 | Memory write strobe |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Word to write |
| mem_rdata | input | 32 | Read word, valid the cycle after mem_rd |
| busy | output | 1 | A sequence is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | One-cycle refusal pulse |
| fault_vec | output | 8 | Vector reported with fault |
| flags | output | 32 | Flags register |
| cs | output | 16 | Code selector register |
| ip | output | 32 | Instruction pointer register |
| ss | output | 16 | Stack selector register |
| sp | output | 32 | Stack pointer register |

## Verification
Vectors 0 to 40, 128 and 255 are swept under both gate kinds. Each runs in three privilege pairings: same level at level 0, level 3 into level 0, and level 2 into level 1. The sweep separates the error-code vectors from plain ones by their frame length and write count, and separates reserved vectors by the fault pulse and the untouched stack. The two gate kinds differ in flags bit 9, and the pairings separate the three-word frame from the five-word frame on a table stack. Every entry is followed by a return, so both the same-level restore and the restore to the outer stack are checked against the context that was loaded before the event.

// File: rtl/irqseq_pkg.sv
package irqseq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_PUSH, S_EFIN, S_POP, S_RFIN
  } seq_st_t;

  // frame slot order for pushes, outermost first
  localparam logic [2:0] SLOT_SS  = 3'd0;
  localparam logic [2:0] SLOT_SP  = 3'd1;
  localparam logic [2:0] SLOT_FL  = 3'd2;
  localparam logic [2:0] SLOT_CS  = 3'd3;
  localparam logic [2:0] SLOT_IP  = 3'd4;
  localparam logic [2:0] SLOT_ERR = 3'd5;
endpackage

// File: rtl/irqseq_vclass.sv
module irqseq_vclass #(
  parameter int          VW       = 8,
  parameter logic [31:0] ERR_MASK = 32'h0002_7D00,
  parameter logic [31:0] RSV_MASK = 32'hFFF8_8000
) (
  input  logic [VW-1:0] vec,
  output logic          pushes_err,
  output logic          reserved
);
  localparam int LOW_CNT = 32;

  logic low_range;
  assign low_range = (vec < VW'(LOW_CNT));

  always_comb begin
    pushes_err = low_range && ERR_MASK[vec[4:0]];
    reserved   = low_range && RSV_MASK[vec[4:0]];
  end
endmodule

// File: rtl/irqseq_stktab.sv
module irqseq_stktab #(
  parameter int NLVL = 4,
  parameter int SELW = 16,
  parameter int W    = 32,
  parameter int LW   = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            wr,
  input  logic [LW-1:0]   wlvl,
  input  logic [SELW-1:0] wss,
  input  logic [W-1:0]    wsp,
  input  logic [LW-1:0]   rlvl,
  output logic [SELW-1:0] rss,
  output logic [W-1:0]    rsp
);
  logic [SELW-1:0] ss_m [NLVL];
  logic [W-1:0]    sp_m [NLVL];

  always_ff @(posedge clk) begin
    if (wr) begin
      ss_m[wlvl] <= wss;
      sp_m[wlvl] <= wsp;
    end
  end

  assign rss = ss_m[rlvl];
  assign rsp = sp_m[rlvl];
endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq
  import irqseq_pkg::*;
#(
  parameter int          W         = 32,
  parameter int          SELW      = 16,
  parameter int          VW        = 8,
  parameter int          NLVL      = 4,
  parameter int          IF_BIT    = 9,
  parameter int          FAULT_VEC = 13,
  parameter logic [31:0] RST_FLAGS = 32'h0000_0002,
  parameter int          LW        = $clog2(NLVL)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ev_valid,
  input  logic [VW-1:0]   ev_vec,
  input  logic            ev_trap,
  input  logic [LW-1:0]   ev_dpl,
  input  logic [SELW-1:0] ev_sel,
  input  logic [W-1:0]    ev_off,
  input  logic [W-1:0]    ev_err,
  input  logic            ret_valid,
  input  logic            ld_ctx,
  input  logic [W-1:0]    ld_flags,
  input  logic [SELW-1:0] ld_cs,
  input  logic [W-1:0]    ld_ip,
  input  logic [SELW-1:0] ld_ss,
  input  logic [W-1:0]    ld_sp,
  input  logic            tab_wr,
  input  logic [LW-1:0]   tab_lvl,
  output logic            mem_wr,
  output logic            mem_rd,
  output logic [W-1:0]    mem_addr,
  output logic [W-1:0]    mem_wdata,
  input  logic [W-1:0]    mem_rdata,
  output logic            busy,
  output logic            done,
  output logic            fault,
  output logic [VW-1:0]   fault_vec,
  output logic [W-1:0]    flags,
  output logic [SELW-1:0] cs,
  output logic [W-1:0]    ip,
  output logic [SELW-1:0] ss,
  output logic [W-1:0]    sp
);
  localparam int         NPOP   = 5;
  localparam logic [W-1:0] WSTEP = W'(4);
  localparam logic [W-1:0] INNER = W'(12);

  seq_st_t st;
  logic [W-1:0]    r_flags, r_ip, r_sp;
  logic [SELW-1:0] r_cs, r_ss;

  // context captured at entry
  logic [SELW-1:0] sv_ss, sv_cs, sv_sel;
  logic [W-1:0]    sv_sp, sv_fl, sv_ip, sv_err, sv_off;
  logic            sv_trap;
  logic [2:0]      idx, last;

  // return-side state
  logic [W-1:0] base;
  logic [2:0]   iss, rd_tag, rtag;
  logic         rv;
  logic [W-1:0] pw [NPOP];

  logic            v_err, v_rsv;
  logic [SELW-1:0] t_ss;
  logic [W-1:0]    t_sp, push_word;
  logic            to_inner, to_outer;

  irqseq_vclass #(.VW(VW)) u_cls (
    .vec(ev_vec), .pushes_err(v_err), .reserved(v_rsv)
  );

  irqseq_stktab #(.NLVL(NLVL), .SELW(SELW), .W(W), .LW(LW)) u_tab (
    .clk(clk), .wr(tab_wr), .wlvl(tab_lvl), .wss(ld_ss), .wsp(ld_sp),
    .rlvl(ev_dpl), .rss(t_ss), .rsp(t_sp)
  );

  assign to_inner = (ev_dpl < r_cs[LW-1:0]);
  assign to_outer = (pw[1][LW-1:0] > r_cs[LW-1:0]);

  always_comb begin
    case (idx)
      SLOT_SS: push_word = W'(sv_ss);
      SLOT_SP: push_word = sv_sp;
      SLOT_FL: push_word = sv_fl;
      SLOT_CS: push_word = W'(sv_cs);
      SLOT_IP: push_word = sv_ip;
      default: push_word = sv_err;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= S_IDLE;
      r_flags <= RST_FLAGS; r_cs <= '0; r_ip <= '0; r_ss <= '0; r_sp <= '0;
      sv_ss <= '0; sv_cs <= '0; sv_sel <= '0; sv_sp <= '0; sv_fl <= '0;
      sv_ip <= '0; sv_err <= '0; sv_off <= '0; sv_trap <= 1'b0;
      idx <= '0; last <= '0; base <= '0; iss <= '0; rd_tag <= '0;
      rtag <= '0; rv <= 1'b0;
      for (int i = 0; i < NPOP; i++) pw[i] <= '0;
      mem_wr <= 1'b0; mem_rd <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      done <= 1'b0; fault <= 1'b0; fault_vec <= '0;
    end else begin
      mem_wr <= 1'b0;
      mem_rd <= 1'b0;
      done   <= 1'b0;
      fault  <= 1'b0;
      rv     <= mem_rd;
      rtag   <= rd_tag;
      if (rv) pw[rtag] <= mem_rdata;
      case (st)
        S_IDLE: begin
          if (ev_valid) begin
            if (v_rsv) begin
              fault     <= 1'b1;
              fault_vec <= VW'(FAULT_VEC);
            end else begin
              sv_ss <= r_ss; sv_sp <= r_sp; sv_fl <= r_flags;
              sv_cs <= r_cs; sv_ip <= r_ip;
              sv_err <= ev_err; sv_sel <= ev_sel; sv_off <= ev_off;
              sv_trap <= ev_trap;
              last <= v_err ? SLOT_ERR : SLOT_IP;
              if (to_inner) begin
                r_ss <= t_ss;
                r_sp <= t_sp;
                idx  <= SLOT_SS;
              end else begin
                idx  <= SLOT_FL;
              end
              st <= S_PUSH;
            end
          end else if (ret_valid) begin
            base <= r_sp;
            iss  <= '0;
            st   <= S_POP;
          end else if (ld_ctx) begin
            r_flags <= ld_flags; r_cs <= ld_cs; r_ip <= ld_ip;
            r_ss <= ld_ss; r_sp <= ld_sp;
          end
        end
        S_PUSH: begin
          mem_wr    <= 1'b1;
          mem_addr  <= r_sp - WSTEP;
          mem_wdata <= push_word;
          r_sp      <= r_sp - WSTEP;
          if (idx == last) st <= S_EFIN;
          else idx <= idx + 3'd1;
        end
        S_EFIN: begin
          r_cs <= sv_sel;
          r_ip <= sv_off;
          if (!sv_trap) r_flags[IF_BIT] <= 1'b0;
          done <= 1'b1;
          st   <= S_IDLE;
        end
        S_POP: begin
          if (iss < 3'(NPOP)) begin
            mem_rd   <= 1'b1;
            mem_addr <= base + (W'(iss) << 2);
            rd_tag   <= iss;
            iss      <= iss + 3'd1;
          end
          if (rv && rtag == 3'(NPOP - 1)) st <= S_RFIN;
        end
        S_RFIN: begin
          r_ip    <= pw[0];
          r_cs    <= pw[1][SELW-1:0];
          r_flags <= pw[2];
          if (to_outer) begin
            r_sp <= pw[3];
            r_ss <= pw[4][SELW-1:0];
          end else begin
            r_sp <= base + INNER;
          end
          done <= 1'b1;
          st   <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy  = (st != S_IDLE);
  assign flags = r_flags;
  assign cs    = r_cs;
  assign ip    = r_ip;
  assign ss    = r_ss;
  assign sp    = r_sp;

  // R9
  rdwr_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(mem_wr && mem_rd));
  // R5
  push_desc_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_wr && $past(mem_wr)) |-> (mem_addr == $past(mem_addr) - WSTEP));
  // R9
  pop_asc_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_rd && $past(mem_rd)) |-> (mem_addr == $past(mem_addr) + WSTEP));
  // R8
  fault_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    fault |-> (fault_vec == VW'(FAULT_VEC) && !mem_wr && !busy));
  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R7
  if_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (done && $past(st) == S_EFIN && !sv_trap) |-> !r_flags[IF_BIT]);
endmodule

// File: tb/sim_irq_frame_seq.sv
module sim_irq_frame_seq;
  localparam int CLK_P = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_P/2) clk = ~clk;

  logic        ev_valid = 0, ev_trap = 0, ret_valid = 0, ld_ctx = 0, tab_wr = 0;
  logic [7:0]  ev_vec = 0;
  logic [1:0]  ev_dpl = 0, tab_lvl = 0;
  logic [15:0] ev_sel = 0, ld_cs = 0, ld_ss = 0;
  logic [31:0] ev_off = 0, ev_err = 0, ld_flags = 0, ld_ip = 0, ld_sp = 0;
  logic        mem_wr, mem_rd, busy, done, fault;
  logic [31:0] mem_addr, mem_wdata, flags, ip, sp;
  logic [31:0] mem_rdata = 0;
  logic [7:0]  fault_vec;
  logic [15:0] cs, ss;

  irq_frame_seq u0 (
    .clk(clk), .rst(rst), .ev_valid(ev_valid), .ev_vec(ev_vec), .ev_trap(ev_trap),
    .ev_dpl(ev_dpl), .ev_sel(ev_sel), .ev_off(ev_off), .ev_err(ev_err),
    .ret_valid(ret_valid), .ld_ctx(ld_ctx), .ld_flags(ld_flags), .ld_cs(ld_cs),
    .ld_ip(ld_ip), .ld_ss(ld_ss), .ld_sp(ld_sp), .tab_wr(tab_wr), .tab_lvl(tab_lvl),
    .mem_wr(mem_wr), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .busy(busy), .done(done), .fault(fault),
    .fault_vec(fault_vec), .flags(flags), .cs(cs), .ip(ip), .ss(ss), .sp(sp)
  );

  // word memory model, one-cycle read latency
  logic [31:0] mem [256];
  int wr_cnt = 0;
  always @(posedge clk) begin
    if (mem_wr) begin
      mem[mem_addr[9:2]] <= mem_wdata;
      wr_cnt <= wr_cnt + 1;
    end
    if (mem_rd) mem_rdata <= mem[mem_addr[9:2]];
  end

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] tss(input int l); return 16'h0010 + 16'(l * 9); endfunction
  function automatic logic [31:0] tsp(input int l); return 32'h380 - 32'(l * 64); endfunction

  task automatic load_ctx(input logic [31:0] f, input logic [15:0] c, input logic [31:0] i,
                          input logic [15:0] s, input logic [31:0] p);
    @(negedge clk);
    ld_ctx = 1; ld_flags = f; ld_cs = c; ld_ip = i; ld_ss = s; ld_sp = p;
    @(negedge clk);
    ld_ctx = 0;
  endtask

  task automatic run_case(input int v, input bit trap, input int cpl, input int dpl);
    logic [31:0] fl, ipv, off, err, start, sp0;
    logic [15:0] csv, sel, ss0;
    logic [31:0] ew [6];
    bit sw, he, rs;
    int nw, n, w0;
    fl  = 32'h0000_0202 | (32'(v) << 12);
    csv = 16'h0020 | 16'(cpl);
    ipv = 32'h0000_1000 + 32'(v);
    ss0 = 16'h0030;
    sp0 = 32'h200;
    sel = 16'h0040 | 16'(dpl);
    off = 32'h8000_0000 + 32'(v * 16);
    err = 32'hE000_0000 | 32'(v);
    sw  = dpl < cpl;
    he  = (v == 8) || (v >= 10 && v <= 14) || (v == 17);
    rs  = (v == 15) || (v >= 19 && v <= 31);
    nw  = 0;
    if (sw) begin ew[0] = 32'(ss0); ew[1] = sp0; nw = 2; end
    ew[nw] = fl; ew[nw+1] = 32'(csv); ew[nw+2] = ipv; nw += 3;
    if (he) begin ew[nw] = err; nw++; end
    start = sw ? tsp(dpl) : sp0;

    load_ctx(fl, csv, ipv, ss0, sp0);
    w0 = wr_cnt;
    @(negedge clk);
    ev_valid = 1; ev_vec = 8'(v); ev_trap = trap; ev_dpl = 2'(dpl);
    ev_sel = sel; ev_off = off; ev_err = err;
    n = 0;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      ev_valid = 0;
      n++;
      if (done || fault) break;
    end

    if (rs) begin
      chk("R8", "fault", 32'(fault), 1);
      chk("R8", "fault cycle", 32'(n), 1);
      chk("R8", "fault_vec", 32'(fault_vec), 13);
      @(negedge clk);
      chk("R8", "fault width", 32'(fault), 0);
      chk("R8", "writes", 32'(wr_cnt - w0), 0);
      chk("R8", "flags kept", flags, fl);
      chk("R8", "cs kept", 32'(cs), 32'(csv));
      chk("R8", "ip kept", ip, ipv);
      chk("R8", "sp kept", sp, sp0);
      chk("R8", "ss kept", 32'(ss), 32'(ss0));
      return;
    end

    chk("R6", "done latency", 32'(n), 32'(nw + 2));
    chk("R4", "write count", 32'(wr_cnt - w0), 32'(nw));
    chk("R6", "cs loaded", 32'(cs), 32'(sel));
    chk("R6", "ip loaded", ip, off);
    chk("R7", "flags after entry", flags, trap ? fl : (fl & ~32'h200));
    chk("R5", "sp after entry", sp, start - 32'(4 * nw));
    chk("R3", "ss after entry", 32'(ss), sw ? 32'(tss(dpl)) : 32'(ss0));
    for (int i = 0; i < nw; i++)
      chk(sw ? "R3" : (i < 3 ? "R2" : "R4"), "frame word",
          mem[8'((start - 32'(4 * (i + 1))) >> 2)], ew[i]);
    @(negedge clk);
    chk("R6", "done width", 32'(done), 0);

    // handler discards the error code before returning
    if (he) load_ctx(flags, cs, ip, ss, sp + 32'd4);
    @(negedge clk);
    ret_valid = 1;
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      ret_valid = 0;
      if (done) break;
    end
    chk("R11", "return done", 32'(done), 1);
    chk("R9", "ip restored", ip, ipv);
    chk("R9", "cs restored", 32'(cs), 32'(csv));
    chk("R9", "flags restored", flags, fl);
    chk(sw ? "R10" : "R9", "sp restored", sp, sp0);
    chk(sw ? "R10" : "R9", "ss restored", 32'(ss), 32'(ss0));
    @(negedge clk);
    chk("R11", "done width", 32'(done), 0);
  endtask

  initial begin
    int vl [43];
    int cp [3], dp [3];
    cp = '{0, 3, 2};
    dp = '{0, 0, 1};
    for (int i = 0; i <= 40; i++) vl[i] = i;
    vl[41] = 128; vl[42] = 255;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "busy", 32'(busy), 0);
    chk("R1", "done", 32'(done), 0);
    chk("R1", "fault", 32'(fault), 0);
    chk("R1", "mem strobes", 32'({mem_wr, mem_rd}), 0);
    chk("R1", "flags", flags, 32'h2);
    chk("R1", "cs/ss", 32'({cs, ss}), 0);
    chk("R1", "ip", ip, 0);
    chk("R1", "sp", sp, 0);
    for (int l = 0; l < 4; l++) begin
      @(negedge clk);
      tab_wr = 1; tab_lvl = 2'(l); ld_ss = tss(l); ld_sp = tsp(l);
    end
    @(negedge clk);
    tab_wr = 0;
    for (int i = 0; i < 43; i++)
      for (int t = 0; t < 2; t++)
        for (int p = 0; p < 3; p++)
          run_case(vl[i], t[0], cp[p], dp[p]);
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      tests++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule